// File: doc/BRIEF.md
# Multi-Target Modular Power-of-Two Scanner

This block walks the powers of two modulo an odd modulus `p` and looks for a small set of residues at the same time. It solves 2^n ≡ t (mod p) for each loaded target `t`. A host computes each target as the negated inverse of a candidate multiplier k modulo p, so a match at exponent n means that p divides k·2^n + 1 for that k. The host also drops the candidates that fail a quadratic-residue test before it loads them. Computing the targets and generating the moduli are outside the block.

A start pulse latches the modulus, up to `NT` target values and one enable bit per target. The block then advances one exponent per clock. It doubles the running residue, reduces it with a single conditional subtraction and compares it against every enabled target in parallel. Each match becomes a (target index, exponent) record. The records leave through a valid/ready stream buffered by a small FIFO. The scan covers every exponent from 1 up to the limit 2^`LIM_LOG2`. A one-cycle done pulse follows once the last record has been taken.

Top module: `p2s_scan`

## Requirements
- R1: After reset, `hit_valid`, `busy` and `done` are all low.
- R2: A start pulse while idle latches `modulus` (odd, at least 3, up to `W` bits wide, checked across the full width), `targets` (target i in bits [i*W +: W]) and `tgt_en`. The first exponent scanned is n=1 with residue 2. Each later exponent takes the previous residue, doubles it and subtracts the modulus once if the result is not below it, so the residue always stays below the modulus.
- R3: A record (i, n) is emitted exactly when target i is enabled and 2^n mod p equals target i. `hit_idx` carries i and `hit_exp` carries n.
- R4: A target whose enable bit is 0 produces no record, even when its value occurs in the walk.
- R5: Records come out in ascending exponent order. When several targets match the same exponent, all of them come out in ascending index order before any record for a later exponent, including when two targets hold the same value.
- R6: Exponents 1 through 2^`LIM_LOG2` inclusive are scanned, and no higher exponent is scanned. The end is detected from bit `LIM_LOG2` of the exponent counter.
- R7: When the output FIFO is full the scan stalls, and no record is lost or duplicated. While `hit_valid` is high and `hit_ready` is low, `hit_idx` and `hit_exp` hold steady.
- R8: `done` is a single-cycle pulse, given once per scan, after the last exponent has been processed and every record has been accepted. In that cycle `busy` and `hit_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a scan when idle |
| modulus | input | W | Odd modulus p, at least 3 |
| targets | input | NT*W | Target residues, target i in bits [i*W +: W] |
| tgt_en | input | NT | Per-target enable |
| hit_valid | output | 1 | A match record is available |
| hit_ready | input | 1 | Consumer accepts the record |
| hit_idx | output | IW | Index of the matching target |
| hit_exp | output | NW | Exponent n of the match |
| busy | output | 1 | Scan or drain in progress |
| done | output | 1 | One-cycle end-of-scan pulse |

## Verification
A small modulus of order 100 tests the basic match rule. One enabled target sits at the first exponent, and a disabled target sits on a value the walk reaches, which separates the enable gating from the compare. Three enabled targets with the same value, plus a disabled copy, show whether same-exponent records are serialized in index order or merged. A modulus of 7 with every residue of its cycle loaded gives a record on every step, with the consumer held off so that the FIFO fills. This separates a true stall from dropped or repeated records. A modulus just below 2^64 exercises the full-width reduction at the last exponent, and one of its targets first appears just past the limit, which exposes an off-by-one in the end detection.

// File: rtl/p2s_pkg.sv
package p2s_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SCAN  = 2'd1,
      ST_DRAIN = 2'd2
   } scan_state_t;
endpackage

// File: rtl/p2s_modstep.sv
// One exponent step: doubles a reduced residue, then one conditional subtraction.
module p2s_modstep #(
   parameter int W = 64
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] modv,
   output logic [W-1:0] nxt
);
   logic [W:0] dbl;
   logic [W:0] sub;

   always_comb begin
      dbl = {cur, 1'b0};
      sub = dbl - {1'b0, modv};
      nxt = sub[W] ? dbl[W-1:0] : sub[W-1:0];
   end
endmodule

// File: rtl/p2s_match.sv
// Parallel compare of the residue against all targets, lowest pending index first.
module p2s_match #(
   parameter int W  = 64,
   parameter int NT = 9,
   localparam int IW = (NT > 1) ? $clog2(NT) : 1
) (
   input  logic [W-1:0]    cur,
   input  logic [NT*W-1:0] tgts,
   input  logic [NT-1:0]   en,
   input  logic [NT-1:0]   served,
   output logic            any,
   output logic            last_one,
   output logic [IW-1:0]   sel
);
   logic [NT-1:0] eq;

   for (genvar g = 0; g < NT; g++) begin : g_cmp
      assign eq[g] = en[g] && !served[g] && (tgts[g*W +: W] == cur);
   end

   always_comb begin
      sel = '0;
      for (int i = NT - 1; i >= 0; i--) begin
         if (eq[i]) sel = IW'(i);
      end
      any      = |eq;
      last_one = ((eq & (eq - NT'(1))) == '0);
   end
endmodule

// File: rtl/p2s_fifo.sv
// First-word fall-through hit buffer; DEPTH picks a single register or a ring.
module p2s_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] din,
   output logic          full,
   output logic          valid,
   input  logic          ready,
   output logic [DW-1:0] dout
);
   if (DEPTH == 1) begin : g_single
      logic          occ_q;
      logic [DW-1:0] dat_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            occ_q <= 1'b0;
            dat_q <= '0;
         end else if (push && !occ_q) begin
            occ_q <= 1'b1;
            dat_q <= din;
         end else if (ready && occ_q) begin
            occ_q <= 1'b0;
         end
      end
      assign full  = occ_q;
      assign valid = occ_q;
      assign dout  = dat_q;
   end else begin : g_ring
      localparam int AW = $clog2(DEPTH);
      localparam int CW = $clog2(DEPTH + 1);
      logic [DW-1:0] mem [DEPTH];
      logic [AW-1:0] wp_q, rp_q;
      logic [CW-1:0] cnt_q;
      logic          do_push, do_pop;

      assign full    = (cnt_q == CW'(DEPTH));
      assign valid   = (cnt_q != '0);
      assign do_push = push && !full;
      assign do_pop  = valid && ready;
      assign dout    = mem[rp_q];

      always_ff @(posedge clk) begin
         if (do_push) mem[wp_q] <= din;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
         end else begin
            if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
            if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
            if (do_push && !do_pop)      cnt_q <= cnt_q + CW'(1);
            else if (do_pop && !do_push) cnt_q <= cnt_q - CW'(1);
         end
      end
   end
endmodule

// File: rtl/p2s_scan.sv
module p2s_scan
   import p2s_pkg::*;
#(
   parameter int W          = 64,
   parameter int NT         = 9,
   parameter int LIM_LOG2   = 26,
   parameter int FIFO_DEPTH = 4,
   localparam int IW = (NT > 1) ? $clog2(NT) : 1,
   localparam int NW = LIM_LOG2 + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [W-1:0]  modulus,
   input  logic [NT*W-1:0] targets,
   input  logic [NT-1:0] tgt_en,
   output logic          hit_valid,
   input  logic          hit_ready,
   output logic [IW-1:0] hit_idx,
   output logic [NW-1:0] hit_exp,
   output logic          busy,
   output logic          done
);
   if (W < 3) begin : g_bad_w
      $error("p2s_scan: W must be at least 3");
   end
   if (NT < 1 || NT > 16) begin : g_bad_nt
      $error("p2s_scan: NT must be 1..16");
   end
   if (LIM_LOG2 < 1) begin : g_bad_lim
      $error("p2s_scan: LIM_LOG2 must be at least 1");
   end
   if (FIFO_DEPTH < 1) begin : g_bad_depth
      $error("p2s_scan: FIFO_DEPTH must be at least 1");
   end

   localparam int DW = IW + NW;

   scan_state_t     state_q;
   logic [W-1:0]    mod_q;
   logic [NT*W-1:0] tgt_q;
   logic [NT-1:0]   en_q;
   logic [W-1:0]    val_q;
   logic [W-1:0]    val_nxt;
   logic [NW-1:0]   exp_q;
   logic [NT-1:0]   served_q;
   logic            done_q;

   logic            m_any, m_last;
   logic [IW-1:0]   m_sel;
   logic            f_full, f_valid;
   logic [DW-1:0]   f_dout;
   logic            push, advance;

   p2s_modstep #(.W(W)) u_step (
      .cur  (val_q),
      .modv (mod_q),
      .nxt  (val_nxt)
   );

   p2s_match #(.W(W), .NT(NT)) u_match (
      .cur      (val_q),
      .tgts     (tgt_q),
      .en       (en_q),
      .served   (served_q),
      .any      (m_any),
      .last_one (m_last),
      .sel      (m_sel)
   );

   p2s_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .din   ({m_sel, exp_q}),
      .full  (f_full),
      .valid (f_valid),
      .ready (hit_ready),
      .dout  (f_dout)
   );

   assign push    = (state_q == ST_SCAN) && m_any && !f_full;
   assign advance = (state_q == ST_SCAN) && (!m_any || (push && m_last));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         mod_q    <= '0;
         tgt_q    <= '0;
         en_q     <= '0;
         val_q    <= '0;
         exp_q    <= '0;
         served_q <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  mod_q    <= modulus;
                  tgt_q    <= targets;
                  en_q     <= tgt_en;
                  val_q    <= W'(2);
                  exp_q    <= NW'(1);
                  served_q <= '0;
                  state_q  <= ST_SCAN;
               end
            end
            ST_SCAN: begin
               if (push && !m_last) served_q[m_sel] <= 1'b1;
               if (advance) begin
                  served_q <= '0;
                  if (exp_q[LIM_LOG2]) begin
                     state_q <= ST_DRAIN;
                  end else begin
                     val_q <= val_nxt;
                     exp_q <= exp_q + NW'(1);
                  end
               end
            end
            ST_DRAIN: begin
               if (!f_valid) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign hit_valid = f_valid;
   assign hit_idx   = f_dout[DW-1:NW];
   assign hit_exp   = f_dout[NW-1:0];
   assign busy      = (state_q != ST_IDLE);
   assign done      = done_q;
endmodule

// File: rtl/p2s_scan_chk.sv
module p2s_scan_chk #(
   parameter int W        = 64,
   parameter int NT       = 9,
   parameter int LIM_LOG2 = 26,
   parameter int IW       = 4,
   parameter int NW       = 27
) (
   input logic          clk,
   input logic          rst_n,
   input logic          hit_valid,
   input logic          hit_ready,
   input logic [IW-1:0] hit_idx,
   input logic [NW-1:0] hit_exp,
   input logic          busy,
   input logic          done,
   input logic [W-1:0]  val,
   input logic [W-1:0]  modv
);
   // R2: the running residue stays reduced below the modulus during a scan
   p_val_reduced_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (val < modv));

   // R3: a record always names an existing target
   p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid |-> (hit_idx < IW'(NT)));

   // R6: reported exponents lie within 1 .. 2^LIM_LOG2
   p_exp_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid |-> ((hit_exp != '0) && (hit_exp <= (NW'(1) << LIM_LOG2))));

   // R7: a record waiting for the consumer does not change
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_valid && !hit_ready) |=> (hit_valid && $stable(hit_idx) && $stable(hit_exp)));

   // R8: done lasts one cycle
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: done only once nothing is pending
   p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!hit_valid && !busy));
endmodule

bind p2s_scan p2s_scan_chk #(
   .W(W), .NT(NT), .LIM_LOG2(LIM_LOG2), .IW(IW), .NW(NW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hit_valid (hit_valid),
   .hit_ready (hit_ready),
   .hit_idx   (hit_idx),
   .hit_exp   (hit_exp),
   .busy      (busy),
   .done      (done),
   .val       (val_q),
   .modv      (mod_q)
);

// File: tb/sim_p2s_scan.sv
module sim_p2s_scan;
   localparam int CLK_PERIOD = 10;
   localparam int W     = 64;
   localparam int NT    = 9;
   localparam int LIM   = 6;
   localparam int DEPTH = 4;
   localparam int IW    = 4;
   localparam int NW    = LIM + 1;
   localparam int LIMIT = 1 << LIM;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [W-1:0]    modulus = '0;
   logic [NT*W-1:0] targets = '0;
   logic [NT-1:0]   tgt_en = '0;
   logic            hit_valid;
   logic            hit_ready = 1'b1;
   logic [IW-1:0]   hit_idx;
   logic [NW-1:0]   hit_exp;
   logic            busy;
   logic            done;

   int n_chk = 0;
   int n_bad = 0;

   logic [63:0] tv [NT];
   logic [NT-1:0] te;
   int exp_idx [256];
   int exp_n   [256];
   int exp_cnt;
   int got_idx [256];
   int got_n   [256];
   int got_cnt;
   int done_cnt;

   always #(CLK_PERIOD / 2) clk = ~clk;

   p2s_scan #(.W(W), .NT(NT), .LIM_LOG2(LIM), .FIFO_DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .modulus(modulus),
      .targets(targets), .tgt_en(tgt_en), .hit_valid(hit_valid),
      .hit_ready(hit_ready), .hit_idx(hit_idx), .hit_exp(hit_exp),
      .busy(busy), .done(done)
   );

   // Records are taken at the next rising edge when valid and ready are both high here.
   always @(negedge clk) begin
      if (rst_n) begin
         if (hit_valid && hit_ready && got_cnt < 256) begin
            got_idx[got_cnt] = int'(hit_idx);
            got_n[got_cnt]   = int'(hit_exp);
            got_cnt++;
         end
         if (done) done_cnt++;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // Independent model: walk 2^n mod p and list records in emission order.
   task automatic model(input logic [63:0] p);
      logic [64:0] v;
      v = 65'd2;
      exp_cnt = 0;
      for (int n = 1; n <= LIMIT; n++) begin
         for (int i = 0; i < NT; i++) begin
            if (te[i] && tv[i] == v[63:0]) begin
               exp_idx[exp_cnt] = i;
               exp_n[exp_cnt]   = n;
               exp_cnt++;
            end
         end
         v = v << 1;
         if (v >= {1'b0, p}) v = v - {1'b0, p};
      end
   endtask

   task automatic clear_targets();
      for (int i = 0; i < NT; i++) tv[i] = '0;
      te = '0;
   endtask

   task automatic run_scan(input logic [63:0] p, input int stall, input string req);
      int waited;
      model(p);
      got_cnt  = 0;
      done_cnt = 0;
      @(posedge clk); #1;
      hit_ready = (stall == 0);
      modulus = p;
      for (int i = 0; i < NT; i++) targets[i*W +: W] = tv[i];
      tgt_en = te;
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      if (stall > 0) begin
         repeat (stall) @(posedge clk);
         @(negedge clk);
         chk(busy == 1'b1, "R7", "busy while stalled", 64'(busy), 64'd1);
         chk(got_cnt == 0, "R7", "nothing taken while stalled", 64'(got_cnt), 64'd0);
         chk(hit_valid == 1'b1, "R7", "record waiting", 64'(hit_valid), 64'd1);
         chk(int'(hit_exp) == exp_n[0], "R7", "held exponent", 64'(hit_exp), 64'(exp_n[0]));
         chk(int'(hit_idx) == exp_idx[0], "R7", "held index", 64'(hit_idx), 64'(exp_idx[0]));
         @(posedge clk); #1;
         hit_ready = 1'b1;
      end
      waited = 0;
      while (waited < 2000) begin
         @(negedge clk);
         if (done) break;
         waited++;
      end
      chk(done == 1'b1, "R8", "done reached", 64'(done), 64'd1);
      chk(busy == 1'b0, "R8", "busy low at done", 64'(busy), 64'd0);
      chk(hit_valid == 1'b0, "R8", "no record at done", 64'(hit_valid), 64'd0);
      repeat (3) @(negedge clk);
      chk(done_cnt == 1, "R8", "single done pulse", 64'(done_cnt), 64'd1);
      chk(got_cnt == exp_cnt, req, "record count", 64'(got_cnt), 64'(exp_cnt));
      for (int k = 0; k < exp_cnt && k < got_cnt; k++) begin
         chk(got_idx[k] == exp_idx[k], req, $sformatf("record %0d index", k),
             64'(got_idx[k]), 64'(exp_idx[k]));
         chk(got_n[k] == exp_n[k], req, $sformatf("record %0d exponent", k),
             64'(got_n[k]), 64'(exp_n[k]));
      end
   endtask

   // R1: idle outputs after reset
   task automatic t_reset();
      @(negedge clk);
      chk(hit_valid == 1'b0, "R1", "hit_valid after reset", 64'(hit_valid), 64'd0);
      chk(busy == 1'b0, "R1", "busy after reset", 64'(busy), 64'd0);
      chk(done == 1'b0, "R1", "done after reset", 64'(done), 64'd0);
   endtask

   // R2, R3, R4: mixed targets, one at n=1, one disabled on a reached value
   task automatic t_basic();
      clear_targets();
      tv[0] = 64'd32; te[0] = 1'b1;
      tv[1] = 64'd1;  te[1] = 1'b1;
      tv[2] = 64'd64; te[2] = 1'b1;
      tv[3] = 64'd2;  te[3] = 1'b1;
      tv[8] = 64'd4;  te[8] = 1'b0;
      run_scan(64'd101, 0, "R3");
      chk(got_cnt > 0 && got_n[0] == 1 && got_idx[0] == 3, "R2",
          "first exponent holds residue 2", 64'(got_n[0]), 64'd1);
      begin
         int seen8;
         seen8 = 0;
         for (int k = 0; k < got_cnt; k++) if (got_idx[k] == 8) seen8++;
         chk(seen8 == 0, "R4", "disabled target silent", 64'(seen8), 64'd0);
      end
   endtask

   // R5: equal targets at one exponent come out by ascending index
   task automatic t_dup();
      clear_targets();
      tv[0] = 64'd32; te[0] = 1'b1;
      tv[3] = 64'd32; te[3] = 1'b1;
      tv[5] = 64'd32; te[5] = 1'b0;
      tv[6] = 64'd32; te[6] = 1'b1;
      run_scan(64'd101, 0, "R5");
      chk(got_cnt == 3 && got_idx[0] == 0 && got_idx[1] == 3 && got_idx[2] == 6,
          "R5", "order of equal targets", 64'(got_idx[1]), 64'd3);
   endtask

   // R7: a record every step while the consumer holds off
   task automatic t_stall();
      clear_targets();
      tv[0] = 64'd1; te[0] = 1'b1;
      tv[1] = 64'd2; te[1] = 1'b1;
      tv[2] = 64'd4; te[2] = 1'b1;
      run_scan(64'd7, 40, "R7");
      chk(got_cnt == LIMIT, "R7", "one record per exponent", 64'(got_cnt), 64'(LIMIT));
   endtask

   // R2, R6: full-width modulus, reduction at the last exponent, nothing past it
   task automatic t_wide();
      logic [63:0] p;
      p = 64'hFFFF_FFFF_FFFF_FFC5;
      clear_targets();
      tv[0] = 64'h8000_0000_0000_0000; te[0] = 1'b1;
      tv[1] = 64'd59;                  te[1] = 1'b1;
      tv[2] = 64'd118;                 te[2] = 1'b1;
      tv[3] = 64'h0000_0100_0000_0000; te[3] = 1'b1;
      run_scan(p, 0, "R2");
      chk(got_cnt == 3, "R6", "records within limit", 64'(got_cnt), 64'd3);
      chk(got_cnt > 0 && got_n[got_cnt-1] == LIMIT && got_idx[got_cnt-1] == 1, "R6",
          "last exponent scanned", 64'(got_n[got_cnt > 0 ? got_cnt-1 : 0]), 64'(LIMIT));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      got_cnt  = 0;
      done_cnt = 0;
      clear_targets();
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_basic();
      t_dup();
      t_stall();
      t_wide();
      summary();
      $finish;
   end
endmodule